// File: doc/BRIEF.md
# Ordered Dial Combination Lock

This block is a clocked lock controller that opens only when three dial operations arrive in a fixed order. Each operation carries a turning direction and a dial value, and is presented for a single cycle with a strobe. The controller keeps its progress in a four-state machine held in two flip-flops, and it reports that progress on a 2-bit code. A separate open flag is decoded from the state alone.

The order of operations is what matters, not only the values. The combination is right 13, then left 22, then right 3. Any strobed operation that breaks the sequence sends the controller back to the start. The one exception is an operation that equals the first step: it counts as a fresh first step. Once open, the lock stays open until a relock pulse or a reset. The combination is fixed when the block is built, through parameters. Software cannot change it.

Top module: `comblock_top`

## Requirements
- R1: While rst_n is low, and right after it is released, progress_o is 00 and open_o is 0. Reset is asynchronous and active low, and it clears the progress at any point in a sequence.
- R2: The strobed sequence (dir_i=1, value 13), (dir_i=0, value 22), (dir_i=1, value 3) moves progress_o through 01, 10 and 11. Each step takes effect on the rising edge where strobe_i is high. Here dir_i=1 means right and dir_i=0 means left.
- R3: The progress code is 00 for idle, 01 for first step done, 10 for two steps done and 11 for open. open_o is 1 exactly when progress_o is 11.
- R4: In states 00, 01 and 10, a strobed operation that is neither the expected next step nor the first step returns progress_o to 00. A matching value with the wrong direction counts as a mismatch.
- R5: In states 00, 01 and 10, a strobed operation equal to the first step (right 13) that is not the expected next step sets progress_o to 01.
- R6: A cycle with strobe_i low and relock_i low leaves progress_o unchanged, whatever dir_i and val_i hold.
- R7: In state 11, strobed operations of any kind have no effect. The lock stays open until relock_i or reset.
- R8: relock_i high on a rising edge sets progress_o to 00 from any state, and it takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| relock_i | input | 1 | Relock request, returns the lock to idle |
| strobe_i | input | 1 | One-cycle valid for a dial operation |
| dir_i | input | 1 | Direction of the operation: 1 right, 0 left |
| val_i | input | VAL_W (5) | Dial value of the operation |
| open_o | output | 1 | High while the lock is open |
| progress_o | output | 2 | Progress code: 00 idle, 01, 10, 11 open |

## Verification
The bench builds the block with its default parameters: 5-bit dial values and the combination right 13, left 22, right 3. With only 32 values and two directions, biased random draws that favour the three combination values often hit each step, both in order and out of order. They also produce wrong-direction near misses and restarts from every state. Directed cases cover the paths the random stream seldom reaches. These are relock and strobe in the same cycle, reset in the middle of a sequence, and long runs of strobes while the lock is open.

// File: rtl/comblock_pkg.sv
package comblock_pkg;

  // Progress state; the encoding is also the externally visible progress code
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_OPEN = 2'b11
  } lock_state_e;

  localparam int NUM_STEPS = 3;

  localparam logic DIR_LEFT  = 1'b0;
  localparam logic DIR_RIGHT = 1'b1;

endpackage

// File: rtl/comblock_match.sv
// Compares one dial operation against a single fixed step of the combination.
module comblock_match #(
  parameter int               VAL_W   = 5,
  parameter logic [VAL_W-1:0] REF_VAL = '0,
  parameter logic             REF_DIR = 1'b1
) (
  input  logic             dir_i,
  input  logic [VAL_W-1:0] val_i,
  output logic             hit_o
);

  always_comb begin
    hit_o = (dir_i == REF_DIR) && (val_i == REF_VAL);
  end

endmodule

// File: rtl/comblock_next.sv
// Next-state logic of the lock sequencer.
module comblock_next
  import comblock_pkg::*;
(
  input  lock_state_e          cur_i,
  input  logic                 relock_i,
  input  logic                 strobe_i,
  input  logic [NUM_STEPS-1:0] hit_i,
  output lock_state_e          nxt_o
);

  lock_state_e restart;

  // Fallback after a mismatch: a first-step match restarts the sequence
  always_comb begin
    restart = hit_i[0] ? ST_ONE : ST_IDLE;
  end

  always_comb begin
    nxt_o = cur_i;
    if (relock_i) begin
      nxt_o = ST_IDLE;
    end else if (strobe_i) begin
      unique case (cur_i)
        ST_IDLE: nxt_o = restart;
        ST_ONE:  nxt_o = hit_i[1] ? ST_TWO  : restart;
        ST_TWO:  nxt_o = hit_i[2] ? ST_OPEN : restart;
        ST_OPEN: nxt_o = ST_OPEN;
        default: nxt_o = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/comblock_top.sv
// Ordered dial combination lock: three direction/value steps open the lock.
module comblock_top
  import comblock_pkg::*;
#(
  parameter int               VAL_W  = 5,
  parameter logic [VAL_W-1:0] STEP0_VAL = 5'd13,
  parameter logic             STEP0_DIR = 1'b1,
  parameter logic [VAL_W-1:0] STEP1_VAL = 5'd22,
  parameter logic             STEP1_DIR = 1'b0,
  parameter logic [VAL_W-1:0] STEP2_VAL = 5'd3,
  parameter logic             STEP2_DIR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             relock_i,
  input  logic             strobe_i,
  input  logic             dir_i,
  input  logic [VAL_W-1:0] val_i,
  output logic             open_o,
  output logic [1:0]       progress_o
);

  localparam logic [VAL_W-1:0] STEP_VALS [NUM_STEPS] = '{STEP0_VAL, STEP1_VAL, STEP2_VAL};
  localparam logic             STEP_DIRS [NUM_STEPS] = '{STEP0_DIR, STEP1_DIR, STEP2_DIR};

  logic [NUM_STEPS-1:0] step_hit;
  lock_state_e          state_q;
  lock_state_e          state_d;
  logic                 state_en;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
    comblock_match #(
      .VAL_W   (VAL_W),
      .REF_VAL (STEP_VALS[g]),
      .REF_DIR (STEP_DIRS[g])
    ) u_match (
      .dir_i (dir_i),
      .val_i (val_i),
      .hit_o (step_hit[g])
    );
  end

  comblock_next u_next (
    .cur_i    (state_q),
    .relock_i (relock_i),
    .strobe_i (strobe_i),
    .hit_i    (step_hit),
    .nxt_o    (state_d)
  );

  // State only moves on a strobe or a relock
  always_comb begin
    state_en = strobe_i | relock_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // Outputs decoded from the state alone
  always_comb begin
    open_o     = (state_q == ST_OPEN);
    progress_o = state_q;
  end

endmodule

// File: rtl/comblock_chk.sv
// Property checker for comblock_top, attached by bind.
module comblock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       relock_i,
  input logic       strobe_i,
  input logic       open_o,
  input logic [1:0] progress_o
);

  assert_open_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    open_o == (progress_o == 2'b11));

  assert_hold_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !relock_i) |=> (progress_o == $past(progress_o)));

  assert_relock_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    relock_i |=> (progress_o == 2'b00));

  assert_open_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (progress_o == 2'b11 && !relock_i) |=> (progress_o == 2'b11));

  // R2: progress advances by at most one step per strobe
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (progress_o != 2'b11 && !relock_i) |=> ({1'b0, progress_o} <= {1'b0, $past(progress_o)} + 3'd1));

  // R4: from idle a strobe can reach at most the first-step state
  assert_idle_reach_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (progress_o == 2'b00) |=> (progress_o[1] == 1'b0));

endmodule

bind comblock_top comblock_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .relock_i   (relock_i),
  .strobe_i   (strobe_i),
  .open_o     (open_o),
  .progress_o (progress_o)
);

// File: tb/comblock_tb.sv
module comblock_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       relock_i = 1'b0;
  logic       strobe_i = 1'b0;
  logic       dir_i = 1'b0;
  logic [4:0] val_i = '0;
  logic       open_o;
  logic [1:0] progress_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [1:0] exp_prog = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  comblock_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .relock_i   (relock_i),
    .strobe_i   (strobe_i),
    .dir_i      (dir_i),
    .val_i      (val_i),
    .open_o     (open_o),
    .progress_o (progress_o)
  );

  // Expected-state model written from the requirements
  function automatic logic [1:0] model_next(logic [1:0] cur, logic rl, logic st,
                                             logic d, logic [4:0] v);
    logic first;
    first = (d == 1'b1) && (v == 5'd13);
    if (rl) return 2'b00;                       // R8
    if (!st) return cur;                        // R6
    case (cur)
      2'b11: return 2'b11;                      // R7
      2'b00: return first ? 2'b01 : 2'b00;
      2'b01: return (d == 1'b0 && v == 5'd22) ? 2'b10 : (first ? 2'b01 : 2'b00);
      default: return (d == 1'b1 && v == 5'd3) ? 2'b11 : (first ? 2'b01 : 2'b00);
    endcase
  endfunction

  task automatic check(string req);
    n_checks++;
    if (progress_o !== exp_prog || open_o !== (exp_prog == 2'b11)) begin
      n_fail++;
      $display("FAIL %s: progress=%b open=%b expected progress=%b open=%b",
               req, progress_o, open_o, exp_prog, (exp_prog == 2'b11));
    end
  endtask

  task automatic op(logic rl, logic st, logic d, logic [4:0] v, string req);
    @(negedge clk);
    relock_i = rl; strobe_i = st; dir_i = d; val_i = v;
    exp_prog = model_next(exp_prog, rl, st, d, v);
    @(posedge clk);
    #1;
    check(req);
    relock_i = 1'b0; strobe_i = 1'b0;
  endtask

  task automatic open_seq(string req);
    op(0, 1, 1, 5'd13, req);
    op(0, 1, 0, 5'd22, req);
    op(0, 1, 1, 5'd3,  req);
  endtask

  initial begin
    #(WATCHDOG * CLK_PERIOD);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    #(CLK_PERIOD * 2 + 3);
    exp_prog = 2'b00;
    check("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release");

    // R2/R3: correct order opens
    open_seq("R2 R3 sequence");
    // R7: strobes while open are ignored, including the first step
    op(0, 1, 1, 5'd13, "R7 first step while open");
    op(0, 1, 0, 5'd7,  "R7 junk while open");
    // R8: relock
    op(1, 0, 0, 5'd0,  "R8 relock from open");

    // R4: wrong direction for step 2
    op(0, 1, 1, 5'd13, "R5 first step");
    op(0, 1, 1, 5'd22, "R4 wrong direction");
    // R4: wrong order
    op(0, 1, 0, 5'd22, "R4 out of order");
    // R5: repeated first step keeps 01, restart from 10
    op(0, 1, 1, 5'd13, "R5 from idle");
    op(0, 1, 1, 5'd13, "R5 repeat in 01");
    op(0, 1, 0, 5'd22, "R2 second step");
    op(0, 1, 1, 5'd13, "R5 restart from 10");
    // R6: idle cycles with changing inputs hold state
    op(0, 0, 0, 5'd22, "R6 no strobe");
    op(0, 0, 1, 5'd3,  "R6 no strobe");
    // R8: relock beats strobe
    op(1, 1, 0, 5'd22, "R8 relock over strobe");
    // R1: async reset mid-sequence
    op(0, 1, 1, 5'd13, "R5 before reset");
    op(0, 1, 0, 5'd22, "R2 before reset");
    @(negedge clk); #2 rst_n = 1'b0; exp_prog = 2'b00;
    #1; check("R1 async reset mid-sequence");
    @(negedge clk); rst_n = 1'b1;
    // Open then hold without strobes
    open_seq("R2 reopen");
    op(0, 0, 1, 5'd3, "R7 held open");

    // Random mix biased toward combination values
    for (int i = 0; i < N_RANDOM; i++) begin
      logic rl, st, d;
      logic [4:0] v;
      int pick;
      rl = ($urandom_range(0, 19) == 0);
      st = ($urandom_range(0, 9) < 7);
      d  = $urandom_range(0, 1);
      pick = $urandom_range(0, 5);
      case (pick)
        0: v = 5'd13;
        1: v = 5'd22;
        2: v = 5'd3;
        default: v = 5'($urandom_range(0, 31));
      endcase
      op(rl, st, d, v, "R4 R5 R6 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule